// File: doc/BRIEF.md
# Input Capture Unit with Noise Filter

This block timestamps edges on an external capture pin against a free-running counter supplied from outside. The pin first goes through a flop synchroniser. An optional filter then lets the level change only after several successive identical samples. An edge detector watches the selected polarity. On a qualifying edge, the counter value present at that clock edge is stored in a capture register, and a sticky flag is set. An interrupt request follows the flag while interrupts are enabled.

The filter always tracks the synchronised pin, so turning it on or off never has to wait for it to settle. The filter enable only picks which level feeds the edge detector. The edge detector compares the present level with the level one cycle earlier. For this reason, changing the polarity select while the pin is quiet cannot produce a capture.

Top module: `capture_unit`

## Requirements
- R1: While reset is asserted and right after it is released, the capture register, the flag and the interrupt request are all 0. The synchroniser, the filter output and the previous-level register all reset to 0.
- R2: With the filter off, a new pin level that is first present at rising clock edge k produces its capture at edge k+2. The flag is 1 after edge k+2 and is still 0 after edge k+1.
- R3: With the filter on, the filtered level changes only after four successive synchronised samples share the new value. A pin pulse of three cycles or fewer produces no capture, and a pulse of four cycles does produce one.
- R4: With the filter on, the capture happens exactly four cycles later than with the filter off, at edge k+6.
- R5: Edge select 1 captures on a rising edge and edge select 0 captures on a falling edge. An edge of the other polarity has no effect on the flag or on the capture register.
- R6: On a capture, the capture register takes the counter input value present at the capture edge. At all other times it holds its value.
- R7: The flag is set by a capture and stays set until a clear strobe is sampled, which clears it at that edge. When a capture and a clear arrive at the same edge, the flag ends up set.
- R8: The interrupt request is 1 exactly when the flag is 1 and the interrupt enable is 1.
- R9: Changing the edge select while the pin level is stable does not cause a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| filt_en_i | input | 1 | 1 selects the filtered level |
| edge_rise_i | input | 1 | 1 = rising edge, 0 = falling edge |
| irq_en_i | input | 1 | Interrupt request enable |
| flag_clr_i | input | 1 | Flag clear strobe |
| count_i | input | CNT_W | Free-running counter value |
| cap_val_o | output | CNT_W | Capture register |
| cap_flag_o | output | 1 | Sticky capture flag |
| cap_irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a four-sample filter and a two-stage synchroniser. With these values the counter is driven with the cycle number, so every captured value shows exactly which edge made the capture. It also puts the two-cycle and six-cycle capture latencies, as well as the three- and four-cycle glitch boundaries of the filter, within reach of short directed sequences. Random pin activity, with occasional changes of mode, polarity, enable and clear, is then compared cycle by cycle against a bench model.

// File: rtl/capture_unit_pkg.sv
package capture_unit_pkg;
  localparam int unsigned DEF_CNT_W       = 16;
  localparam int unsigned DEF_FILT_LEN    = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/capture_sync.sv
module capture_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d_i;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/capture_filter.sv
module capture_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic lvl_o
);
  localparam int unsigned HW = FILT_LEN - 1;

  logic [HW-1:0] hist_q, hist_d;
  logic          lvl_q, lvl_d;
  logic          all_hi, all_lo;

  generate
    if (HW == 1) begin : g_short
      always_comb hist_d = din_i;
    end else begin : g_long
      always_comb hist_d = {hist_q[HW-2:0], din_i};
    end
  endgenerate

  always_comb begin
    all_hi = din_i & (&hist_q);
    all_lo = ~din_i & ~(|hist_q);
    lvl_d  = lvl_q;
    if (all_hi)      lvl_d = 1'b1;
    else if (all_lo) lvl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  AST_FILT_NEW_LEVEL_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(din_i) == lvl_q)); // R3
endmodule

// File: rtl/capture_edge.sv
module capture_edge
  import capture_unit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,
  input  edge_pol_e pol_i,
  output logic      hit_o
);
  logic prev_q;
  logic hit_d;

  always_comb begin
    if (pol_i == EDGE_RISE) hit_d = lvl_i & ~prev_q;
    else                    hit_d = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign hit_o = hit_d;

  AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (lvl_i == pol_i)); // R5
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (lvl_i != prev_q)); // R9
endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import capture_unit_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned FILT_LEN    = DEF_FILT_LEN,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             cap_irq_o
);
  logic             pin_sync;
  logic             pin_filt;
  logic             lvl_sel;
  logic             cap_hit;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;
  edge_pol_e        pol;

  capture_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cap_pin_i),
    .q_o   (pin_sync)
  );

  capture_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .din_i (pin_sync),
    .lvl_o (pin_filt)
  );

  assign lvl_sel = filt_en_i ? pin_filt : pin_sync;
  assign pol     = edge_rise_i ? EDGE_RISE : EDGE_FALL;

  capture_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl_sel),
    .pol_i (pol),
    .hit_o (cap_hit)
  );

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    if (flag_clr_i) flag_d = 1'b0;
    if (cap_hit) begin
      cap_d  = count_i;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_val_o  = cap_q;
  assign cap_flag_o = flag_q;
  assign cap_irq_o  = flag_q & irq_en_i;

  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> cap_flag_o); // R7
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !cap_hit) |=> !cap_flag_o); // R7
  AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_hit |=> $stable(cap_val_o)); // R6
  AST_VALUE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (cap_val_o == $past(count_i))); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq_o |-> irq_en_i); // R8
endmodule

// File: tb/capture_unit_tb.sv
`timescale 1ns/1ps
module capture_unit_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pin, fen, sel, ie, clr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cap_val;
  logic          cap_flag, cap_irq;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  // bench model state
  logic       m_s1, m_s2, m_f, m_prev, m_flag;
  logic [2:0] m_h;
  logic [CW-1:0] m_cap;

  always #2.5 clk = ~clk;

  capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cap_pin_i(pin), .filt_en_i(fen),
    .edge_rise_i(sel), .irq_en_i(ie), .flag_clr_i(clr), .count_i(cnt),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag), .cap_irq_o(cap_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic edge_hit(input logic lvl, input logic prv, input logic rise);
    return rise ? (lvl & ~prv) : (~lvl & prv);
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_f = 0; m_prev = 0; m_flag = 0; m_h = 0; m_cap = 0;
  endtask

  // advance model by one edge using the inputs applied for it
  task automatic model_edge();
    logic lvl, hit, nf;
    lvl = fen ? m_f : m_s2;
    hit = edge_hit(lvl, m_prev, sel);
    if (clr) m_flag = 0;
    if (hit) begin m_flag = 1; m_cap = cnt; end
    nf = m_f;
    if (m_s2 && (&m_h)) nf = 1;
    else if (!m_s2 && !(|m_h)) nf = 0;
    m_prev = lvl;
    m_f    = nf;
    m_h    = {m_h[1:0], m_s2};
    m_s2   = m_s1;
    m_s1   = pin;
  endtask

  task automatic step(input logic p, input logic e, input logic s, input logic i, input logic c);
    @(negedge clk);
    pin = p; fen = e; sel = s; ie = i; clr = c; cnt = cyc[CW-1:0];
    @(posedge clk);
    model_edge();
    cyc++;
    #1;
    chk("R6 model capture value", 32'(cap_val), 32'(m_cap));
    chk("R7 model flag", 32'(cap_flag), 32'(m_flag));
    chk("R8 model irq", 32'(cap_irq), 32'(m_flag & ie));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t0;
    logic rp, rf, rs, ri;
    void'($urandom(32'd1234));
    rst_n = 0; pin = 0; fen = 0; sel = 0; ie = 0; clr = 0; cnt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset cap", 32'(cap_val), 0);
    chk("R1 reset flag", 32'(cap_flag), 0);
    rst_n = 1;
    step(0, 0, 1, 1, 0);
    chk("R1 after release irq", 32'(cap_irq), 0);
    repeat (5) step(0, 0, 1, 1, 0);

    // R2 unfiltered rising latency and R6 value
    t0 = cyc;
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    chk("R2 no capture at k+1", 32'(cap_flag), 0);
    step(1, 0, 1, 1, 0);
    chk("R2 flag at k+2", 32'(cap_flag), 1);
    chk("R6 captured count", 32'(cap_val), 32'(t0 + 2));
    chk("R8 irq with enable", 32'(cap_irq), 1);
    step(1, 0, 1, 0, 0);
    chk("R8 irq masked", 32'(cap_irq), 0);
    step(1, 0, 1, 1, 1);
    chk("R7 clear", 32'(cap_flag), 0);

    // R5 falling edge ignored with rising select
    repeat (6) step(0, 0, 1, 1, 0);
    chk("R5 opposite edge ignored flag", 32'(cap_flag), 0);
    chk("R5 opposite edge ignored value", 32'(cap_val), 32'(t0 + 2));

    // R9 select toggles with quiet pin
    repeat (6) step(1, 0, 0, 1, 0);
    step(1, 0, 1, 1, 0);
    step(1, 0, 0, 1, 0);
    step(1, 0, 1, 1, 0);
    step(1, 0, 0, 1, 0);
    chk("R9 no capture from select change", 32'(cap_flag), 0);

    // R4 filtered falling latency
    t0 = cyc;
    step(0, 1, 0, 1, 0);
    repeat (5) step(0, 1, 0, 1, 0);
    chk("R4 no capture at k+5", 32'(cap_flag), 0);
    step(0, 1, 0, 1, 0);
    chk("R4 flag at k+6", 32'(cap_flag), 1);
    chk("R4 captured count", 32'(cap_val), 32'(t0 + 6));
    step(0, 1, 0, 1, 1);

    // R3 glitch of three cycles rejected, four accepted
    repeat (8) step(1, 1, 0, 1, 0);
    repeat (3) step(0, 1, 0, 1, 0);
    repeat (8) step(1, 1, 0, 1, 0);
    chk("R3 short pulse rejected", 32'(cap_flag), 0);
    repeat (4) step(0, 1, 0, 1, 0);
    repeat (8) step(1, 1, 0, 1, 0);
    chk("R3 four-cycle pulse captured", 32'(cap_flag), 1);
    step(1, 1, 0, 1, 1);

    // R7 capture wins over simultaneous clear
    repeat (6) step(0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 1);
    t0 = cyc;
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 1, 1);
    chk("R7 capture beats clear", 32'(cap_flag), 1);
    chk("R7 value on contested edge", 32'(cap_val), 32'(t0 + 2));

    // random phase against the model
    rp = 1; rf = 0; rs = 1; ri = 1;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(5) == 0)   rp = ~rp;
      if ($urandom_range(199) == 0) rf = ~rf;
      if ($urandom_range(49) == 0)  rs = ~rs;
      if ($urandom_range(19) == 0)  ri = ~ri;
      step(rp, rf, rs, ri, ($urandom_range(9) == 0));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule